// File: doc/BRIEF.md
# SPI Peripheral with MISO Readback Check

This block is the serial port of a sensor-style device. It accepts fixed 32-bit frames in SPI mode 0 (clock idles low, data captured on the rising SCLK edge, most significant bit first). Each frame carries one request: a register read, a register write or a sensor-data request. Replies are pipelined, so the answer to a request is shifted out while the host sends the next frame. The serial lines are oversampled by the block's system clock, so SCLK and chip select must be slow relative to `clk`.

While it drives MISO, the block reads the pad back through `miso_pad_in` on every rising SCLK edge and compares it with the bit it meant to send. One differing bit anywhere marks the whole transfer as faulted and sets a sticky error flag in the status register. At the end of a faulted transfer a write is still carried out, while a read or sensor-data request is dropped. In all three cases the next reply is replaced by an error word. The `inject_flip` input inverts the driven bit so that a fault can be forced in test.

Command frame: bits [31:30] opcode (00 none, 01 read, 10 write, 11 sensor data), [29:24] address, [23:8] write data, [7:0] ignored. Reply frame: [31:28] status code, [27:24] zero, [23:8] data, [7:0] zero.

Top module: `spi_readback_slave`

## Requirements
- R1: MOSI is captured on each rising SCLK edge while `cs_n` is low, MSB first. The first MISO bit is presented after `cs_n` falls and each later bit after a falling SCLK edge. MISO is 0 whenever `cs_n` is high.
- R2: The reply to the request in one frame is shifted out during the next frame. The first frame after reset returns all zeros.
- R3: Opcode 01 reads the 16-bit register at address [29:24]. Addresses 0 to NREGS-1 are general registers that reset to 0. The reply is status 4'h1 with the register value in bits [23:8].
- R4: Opcode 10 writes bits [23:8] to the addressed general register. The reply is status 4'h1 with the written data echoed in bits [23:8].
- R5: Opcode 11 captures `sample_in` at the end of the frame. The reply is status 4'h1 with that value in bits [23:8].
- R6: Every MISO bit is compared with the pad readback on the rising SCLK edge. Any single mismatch faults the transfer.
- R7: Bit 0 of the status register at address 6'h3F is a sticky MISO error flag. A mismatch sets it. Only a write with data bit 0 equal to 1 to that address clears it.
- R8: A read in a faulted transfer is not performed. The next reply is the error word 32'hE000_0000 (status 4'hE, data zero).
- R9: A write in a faulted transfer is still performed. The next reply is nevertheless the error word 32'hE000_0000.
- R10: A sensor-data request in a faulted transfer is dropped. The next reply is the error word 32'hE000_0000.
- R11: A frame that is not exactly 32 bits long is ignored: no register is written and the pending reply is unchanged. Opcode 00 yields an all-zero reply.
- R12: The per-transfer fault mark clears when `cs_n` goes high, so the next clean transfer gets a normal reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low, frames a transfer |
| mosi | input | 1 | Serial data from the host |
| inject_flip | input | 1 | Inverts the driven MISO bit to force a fault |
| miso_pad_in | input | 1 | Readback of the MISO pad |
| sample_in | input | 16 | Current sensor value |
| miso | output | 1 | Serial data to the host |

## Verification
A wrong bit in the transmit shift register shows up as a corrupted word on MISO in the very next frame. A lost or stuck fault mark shows up one frame later as a normal reply where the error word belongs, or the reverse. A stuck sticky flag is seen by reading address 6'h3F: its value comes out in the frame after the read. A write that was wrongly dropped after a fault, or wrongly performed after a short frame, is only exposed by a later read, two frames after the write.

// File: rtl/spi_readback_slave.sv
module spi_readback_slave #(
  parameter int NREGS = 4,
  parameter logic [5:0] STAT_ADDR = 6'h3F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic        inject_flip,
  input  logic        miso_pad_in,
  input  logic [15:0] sample_in,
  output logic        miso
);
  localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [31:0] ERR_WORD = {4'hE, 28'h0};

  logic        sclk_q, cs_q;
  logic [31:0] rx_sr, tx_sr, reply_q, next_reply;
  logic [5:0]  cnt;
  logic        frame_err, sticky;
  logic [15:0] regs [NREGS];
  logic [15:0] rdata;

  wire sclk_rise = sclk & ~sclk_q & ~cs_n;
  wire sclk_fall = ~sclk & sclk_q & ~cs_n;
  wire cs_fall   = cs_q & ~cs_n;
  wire cs_rise   = ~cs_q & cs_n;
  wire done      = cs_rise && (cnt == 6'd32);
  wire [1:0]  op   = rx_sr[31:30];
  wire [5:0]  addr = rx_sr[29:24];
  wire [15:0] wdat = rx_sr[23:8];
  wire in_file   = addr < 6'(NREGS);
  wire mismatch  = sclk_rise && (miso_pad_in != tx_sr[31]);
  wire stat_clr  = done && op == 2'b10 && addr == STAT_ADDR && wdat[0];

  assign miso = ~cs_n & (tx_sr[31] ^ inject_flip);

  always_comb begin
    rdata = 16'h0;
    if (in_file) rdata = regs[addr[AW-1:0]];
    else if (addr == STAT_ADDR) rdata = {15'h0, sticky};
  end

  always_comb begin
    case (op)
      2'b01:   next_reply = frame_err ? ERR_WORD : {4'h1, 4'h0, rdata, 8'h0};
      2'b10:   next_reply = frame_err ? ERR_WORD : {4'h1, 4'h0, wdat, 8'h0};
      2'b11:   next_reply = frame_err ? ERR_WORD : {4'h1, 4'h0, sample_in, 8'h0};
      default: next_reply = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      rx_sr     <= '0;
      tx_sr     <= '0;
      reply_q   <= '0;
      cnt       <= '0;
      frame_err <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_fall) begin
        tx_sr <= reply_q;
        cnt   <= '0;
      end else begin
        if (sclk_rise) begin
          rx_sr <= {rx_sr[30:0], mosi};
          if (cnt != 6'h3F) cnt <= cnt + 6'd1;
        end
        if (sclk_fall) tx_sr <= {tx_sr[30:0], 1'b0};
      end
      if (cs_n) frame_err <= 1'b0;
      else if (mismatch) frame_err <= 1'b1;
      if (mismatch) sticky <= 1'b1;
      else if (stat_clr) sticky <= 1'b0;
      if (done) reply_q <= next_reply;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (done && op == 2'b10 && in_file) begin
      regs[addr[AW-1:0]] <= wdat;
    end
  end

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);
  p_mismatch_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> (frame_err && sticky));
  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky) |-> $past(stat_clr));
  p_fault_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frame_err && op != 2'b00) |=> (reply_q == ERR_WORD));
  p_short_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != 6'd32) |=> $stable(reply_q));
  p_xfer_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !frame_err);
endmodule

// File: tb/test_spi_readback_slave.sv
`timescale 1ns/1ps
module test_spi_readback_slave;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0, inject_flip = 0;
  logic [15:0] sample_in = 16'h0;
  logic miso;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_readback_slave i_spi_readback_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .inject_flip(inject_flip), .miso_pad_in(miso), .sample_in(sample_in),
    .miso(miso));

  localparam logic [31:0] ERRW = 32'hE000_0000;
  localparam logic [5:0]  STAT = 6'h3F;

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
    return {op, a, d, 8'h00};
  endfunction
  function automatic logic [31:0] ok(input logic [15:0] d);
    return {4'h1, 4'h0, d, 8'h00};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] cmd, input logic [31:0] flip, input int nbits,
                      output logic [31:0] got);
    got = '0;
    cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      inject_flip = flip[31-i];
      mosi = cmd[31-i];
      repeat (3) @(negedge clk);
      got[31-i] = miso;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
      repeat (1) @(negedge clk);
    end
    inject_flip = 0;
    repeat (3) @(negedge clk);
    cs_n = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic frame(input string tag, input logic [31:0] cmd, input logic [31:0] flip,
                       input logic [31:0] exp);
    logic [31:0] g;
    xfer(cmd, flip, 32, g);
    chk(tag, g, exp);
  endtask

  task automatic t_reset;
    chk("R1 idle miso low", {31'h0, miso}, 32'h0);
    frame("R2 first reply zero", mk(2'b01, 6'd0, 16'h0), 0, 32'h0);
  endtask

  task automatic t_write_read;
    frame("R3 read reg0 reset", mk(2'b10, 6'd2, 16'h1234), 0, ok(16'h0));
    frame("R4 write echo", mk(2'b01, 6'd2, 16'h0), 0, ok(16'h1234));
    frame("R3 read reg2", mk(2'b01, 6'd3, 16'h0), 0, ok(16'h1234));
    frame("R3 read reg3 zero", 32'h0, 0, ok(16'h0));
  endtask

  task automatic t_sensor;
    sample_in = 16'hA5C3;
    frame("R11 opcode 00 zero reply", mk(2'b11, 6'd0, 16'h0), 0, 32'h0);
    sample_in = 16'h0;
    frame("R5 sensor value", 32'h0, 0, ok(16'hA5C3));
  endtask

  task automatic t_fault_read;
    frame("R6 injected bit seen", mk(2'b01, 6'd2, 16'h0), 32'h0000_0020, 32'h0000_0020);
    frame("R8 faulted read error", mk(2'b01, STAT, 16'h0), 0, ERRW);
    frame("R7 flag set", 32'h0, 0, ok(16'h0001));
  endtask

  task automatic t_clear;
    frame("R7 pre clear", mk(2'b10, STAT, 16'h0000), 0, 32'h0);
    frame("R7 write zero echo", mk(2'b01, STAT, 16'h0), 0, ok(16'h0000));
    frame("R7 flag kept on write 0", mk(2'b10, STAT, 16'h0001), 0, ok(16'h0001));
    frame("R7 clear echo", mk(2'b01, STAT, 16'h0), 0, ok(16'h0001));
    frame("R7 flag cleared", 32'h0, 0, ok(16'h0000));
  endtask

  task automatic t_fault_write;
    frame("R6 first bit flip", mk(2'b10, 6'd1, 16'hBEEF), 32'h8000_0000, 32'h8000_0000);
    frame("R9 faulted write error", mk(2'b01, 6'd1, 16'h0), 0, ERRW);
    frame("R9 write performed", 32'h0, 0, ok(16'hBEEF));
  endtask

  task automatic t_fault_sensor;
    sample_in = 16'h7777;
    frame("R6 last bit flip", mk(2'b11, 6'd0, 16'h0), 32'h0000_0001, 32'h0000_0001);
    frame("R10 faulted sensor error", 32'h0, 0, ERRW);
    frame("R12 clean after fault", mk(2'b11, 6'd0, 16'h0), 0, 32'h0);
    frame("R12 normal sensor reply", 32'h0, 0, ok(16'h7777));
  endtask

  task automatic t_short;
    logic [31:0] g;
    xfer(mk(2'b10, 6'd0, 16'h5555), 0, 20, g);
    frame("R11 reply unchanged", mk(2'b01, 6'd0, 16'h0), 0, 32'h0);
    frame("R11 no write", 32'h0, 0, ok(16'h0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    t_reset;
    t_write_read;
    t_sensor;
    t_fault_read;
    t_clear;
    t_fault_write;
    t_fault_sensor;
    t_short;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule